// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Bit Controller

This block keeps a per-function table of message-signalled interrupt vectors and the array of pending bits that goes with it. Software reaches both through a small register port. Each access carries a region select, a byte offset, a width flag for 4 or 8 bytes and little-endian data. Device logic raises per-vector interrupt requests. For each request the block either emits a message right away or records it as pending. The message goes out on a downstream port as address, data and vector index under a valid/ready handshake.

The block takes the function-level enable and function-mask bits from a message-control input. A vector that was pending is delivered later, when the vector is unmasked through a table write or when the whole function is unmasked. The function unmask starts a scan over all vectors in ascending order. Every delivery clears the pending bit of its vector. The vector count is a parameter (default 8, at most 2048), and the block reports the count minus one as the table-size value.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset every table entry has address and data zero and vector control equal to 1 (masked). All pending bits are zero and no message is offered.
- R2: Each vector owns 16 bytes of table space starting at index*16. A 4-byte access at relative offset 0x0 reaches address low, 0x4 address high, 0x8 message data and 0xC vector control, whose bit 0 is the vector mask.
- R3: An 8-byte table access at offset 0x0 carries {address high, address low}. One at 0x8 carries {vector control, data}, with the first-named field in bits 63:32. Any other offset, or a 4-byte access whose offset bits 1:0 are not zero, reads as zero and leaves the table unchanged on a write.
- R4: The pending region packs vector v into 64-bit word v/64 at bit v%64. It reads as a whole 8-byte word at word offset 0x0, or as a 4-byte low half at 0x0 and high half at 0x4. Writes to it change nothing.
- R5: Read data appears on reg_rdata with reg_rvalid high in the cycle after the read request, and reg_rvalid is low otherwise.
- R6: A request on a vector while enable (message-control bit 15) is 1, function mask (bit 14) is 0 and the vector mask is 0 produces one message. The message carries address {high, low}, the entry's data and the vector index, and the vector's pending bit stays clear.
- R7: A request while the block is disabled, while the function is masked or while the vector is masked sets the vector's pending bit and emits no message. Setting the enable bit later does not by itself deliver it.
- R8: A table write that turns a vector's mask bit from 1 to 0 emits that vector's message and clears its pending bit, provided the bit was set, the block is enabled and the function is unmasked. A write that leaves the entry unchanged, or that leaves the vector masked, emits nothing.
- R9: When the function mask falls from 1 to 0 while enabled, every unmasked pending vector is delivered in ascending index order, one per cycle, and its pending bit is cleared. Masked vectors stay pending.
- R10: While msg_valid is high and msg_ready is low, msg_valid, msg_addr, msg_data and msg_vec hold their values.
- R11: table_size reports the vector count minus one.
- R12: A per-vector unmask while the function is masked emits nothing and leaves the pending bit set. The later function unmask delivers that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_space | input | 1 | 0 = vector table, 1 = pending-bit region |
| reg_off | input | OFF_W | Byte offset within the selected region |
| reg_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata | input | 64 | Write data, little-endian, 4-byte writes use bits 31:0 |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 64 | Read data |
| msg_ctl | input | 16 | Message control: bit 15 enable, bit 14 function mask |
| table_size | output | 11 | Vector count minus one |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Downstream accepts message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VEC_W | Vector index of the message |

## Verification
The bench builds the block with NUM_VEC = 70, so the table index is 7 bits wide and the pending region spans two 64-bit words. With this count, vector 65 lands in the second word and vector 63 in the upper half of the first. The function-unmask scan can then be watched as it crosses a word boundary in ascending order (2, 5, 65). A held-off ready makes the output stall visible.

// File: rtl/msix_pkg.sv
// Package: shared entry type, control-bit positions and access helpers
// for the MSI-X vector controller. Assumes little-endian 64-bit data.
package msix_pkg;

    localparam int MAX_VECTORS = 2048;
    localparam int CTL_FMASK_BIT = 14;
    localparam int CTL_ENABLE_BIT = 15;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] data;
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
    } msix_entry_t;

    localparam msix_entry_t ENTRY_RESET = '{ctl: 32'd1, data: 32'd0, addr_hi: 32'd0, addr_lo: 32'd0};

    // Apply one register write to an entry; unsupported offsets leave it as is.
    function automatic msix_entry_t entry_write(msix_entry_t e, logic [3:0] sub,
                                                logic size8, logic [63:0] w);
        msix_entry_t r;
        r = e;
        if (!size8) begin
            case (sub)
                4'h0: r.addr_lo = w[31:0];
                4'h4: r.addr_hi = w[31:0];
                4'h8: r.data    = w[31:0];
                4'hC: r.ctl     = w[31:0];
                default: ;
            endcase
        end else begin
            case (sub)
                4'h0: begin r.addr_lo = w[31:0]; r.addr_hi = w[63:32]; end
                4'h8: begin r.data    = w[31:0]; r.ctl     = w[63:32]; end
                default: ;
            endcase
        end
        return r;
    endfunction

    // Produce read data for one entry; unsupported offsets read as zero.
    function automatic logic [63:0] entry_read(msix_entry_t e, logic [3:0] sub, logic size8);
        logic [63:0] r;
        r = '0;
        if (!size8) begin
            case (sub)
                4'h0: r = {32'd0, e.addr_lo};
                4'h4: r = {32'd0, e.addr_hi};
                4'h8: r = {32'd0, e.data};
                4'hC: r = {32'd0, e.ctl};
                default: r = '0;
            endcase
        end else begin
            case (sub)
                4'h0: r = {e.addr_hi, e.addr_lo};
                4'h8: r = {e.ctl, e.data};
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/msix_table.sv
// Vector table storage. Holds NUM_VEC entries, applies table writes,
// produces combinational read data and a one-cycle pulse per vector
// whose mask bit fell from 1 to 0 by a write (unchanged writes give none).
// Assumes the caller asserts wr_en only for table-region writes.
module msix_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VEC_W = 3,
    parameter int OFF_W = VEC_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFF_W-1:0]    off,
    input  logic                size8,
    input  logic [63:0]         wdata,
    output logic [63:0]         rdata,
    output msix_entry_t         ent_o [NUM_VEC],
    output logic [NUM_VEC-1:0]  vmask,
    output logic [NUM_VEC-1:0]  unmask_pulse
);

    localparam int IDX_W = OFF_W - 4;

    logic [IDX_W-1:0] idx;
    logic [3:0]       sub;
    msix_entry_t      ent [NUM_VEC];
    msix_entry_t      nxt [NUM_VEC];

    assign idx = off[OFF_W-1:4];
    assign sub = off[3:0];

    // Next value of every entry given the current write.
    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            if (wr_en && (int'(idx) == v))
                nxt[v] = entry_write(ent[v], sub, size8, wdata);
            else
                nxt[v] = ent[v];
        end
    end

    // Entry registers and mask-fall pulses.
    always_ff @(posedge clk) begin
        for (int v = 0; v < NUM_VEC; v++) begin
            if (!rst_n) begin
                ent[v]          <= ENTRY_RESET;
                unmask_pulse[v] <= 1'b0;
            end else begin
                ent[v]          <= nxt[v];
                unmask_pulse[v] <= ent[v].ctl[0] & ~nxt[v].ctl[0];
            end
        end
    end

    // Expose entries and per-vector masks.
    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            ent_o[v] = ent[v];
            vmask[v] = ent[v].ctl[0];
        end
    end

    // Read mux over the addressed entry.
    always_comb begin
        rdata = '0;
        for (int v = 0; v < NUM_VEC; v++)
            if (int'(idx) == v) rdata = entry_read(ent[v], sub, size8);
    end

endmodule

// File: rtl/msix_pending.sv
// Pending-bit and delivery-schedule state. A vector is "due" when it is
// scheduled for delivery; due vectors that lose eligibility fall back to
// pending. Assumes take is a one-hot (or zero) vector from the sender.
module msix_pending #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq,
    input  logic [NUM_VEC-1:0] vmask,
    input  logic [NUM_VEC-1:0] unmask_pulse,
    input  logic               fn_en,
    input  logic               fn_mask,
    input  logic [NUM_VEC-1:0] take,
    output logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] due,
    output logic [NUM_VEC-1:0] elig
);

    logic               fn_mask_q;
    logic               fn_unmask_evt;
    logic [NUM_VEC-1:0] set_due;

    assign elig          = {NUM_VEC{fn_en & ~fn_mask}} & ~vmask;
    assign fn_unmask_evt = fn_mask_q & ~fn_mask;
    assign set_due       = elig & (irq | ({NUM_VEC{fn_unmask_evt}} & pend) | (unmask_pulse & pend));

    // Remember the function mask to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) fn_mask_q <= 1'b1;
        else        fn_mask_q <= fn_mask;
    end

    // Update the due schedule and pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due  <= '0;
            pend <= '0;
        end else begin
            due  <= set_due | (due & elig & ~take);
            pend <= (pend & ~take) | ((irq | due) & ~elig);
        end
    end

endmodule

// File: rtl/msix_sender.sv
// Message output stage. Picks the lowest-index candidate each cycle the
// output register is free or being accepted, and holds the message stable
// while ready is low. Assumes cand bits index valid entries.
module msix_sender
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VEC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] cand,
    input  msix_entry_t        ent [NUM_VEC],
    input  logic               msg_ready,
    output logic [NUM_VEC-1:0] take,
    output logic               msg_valid,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [VEC_W-1:0]   msg_vec
);

    logic [NUM_VEC-1:0] grant;
    logic [VEC_W-1:0]   gidx;
    msix_entry_t        gent;
    logic               load;

    assign grant = cand & (~cand + NUM_VEC'(1));
    assign load  = (|cand) & (~msg_valid | msg_ready);
    assign take  = load ? grant : '0;

    // Encode the granted vector and select its entry.
    always_comb begin
        gidx = '0;
        gent = ENTRY_RESET;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (grant[i]) begin
                gidx = VEC_W'(i);
                gent = ent[i];
            end
        end
    end

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            msg_vec   <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= {gent.addr_hi, gent.addr_lo};
            msg_data  <= gent.data;
            msg_vec   <= gidx;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/msix_vec_ctrl.sv
// Top of the MSI-X vector controller: register port decode, pending-region
// read mux, read-data register and the wiring of table, pending and sender.
// Assumes 2 <= NUM_VEC <= 2048 and one register access at most per cycle.
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int OFF_W = VEC_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic               reg_space,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic               reg_size8,
    input  logic [63:0]        reg_wdata,
    output logic               reg_rvalid,
    output logic [63:0]        reg_rdata,
    input  logic [15:0]        msg_ctl,
    output logic [10:0]        table_size,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [VEC_W-1:0]   msg_vec
);

    localparam int PBA_WORDS = NUM_VEC / 64 + 1;
    localparam int PW_W = OFF_W - 3;

    msix_entry_t        ent [NUM_VEC];
    logic [NUM_VEC-1:0] vmask, unmask_pulse, pend, due, elig, take;
    logic [63:0]        tbl_rdata, pba_word, pba_rdata;
    logic [PBA_WORDS*64-1:0] pba_flat;
    logic [PW_W-1:0]    pw_idx;
    logic               unused_ctl;

    assign table_size = 11'(NUM_VEC - 1);
    assign unused_ctl = ^msg_ctl[13:0];

    msix_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .OFF_W(OFF_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_valid & reg_write & ~reg_space),
        .off          (reg_off),
        .size8        (reg_size8),
        .wdata        (reg_wdata),
        .rdata        (tbl_rdata),
        .ent_o        (ent),
        .vmask        (vmask),
        .unmask_pulse (unmask_pulse)
    );

    msix_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq          (irq_req),
        .vmask        (vmask),
        .unmask_pulse (unmask_pulse),
        .fn_en        (msg_ctl[CTL_ENABLE_BIT]),
        .fn_mask      (msg_ctl[CTL_FMASK_BIT]),
        .take         (take),
        .pend         (pend),
        .due          (due),
        .elig         (elig)
    );

    msix_sender #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_send (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand      (due & elig),
        .ent       (ent),
        .msg_ready (msg_ready),
        .take      (take),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .msg_vec   (msg_vec)
    );

    assign pba_flat = {{(PBA_WORDS*64-NUM_VEC){1'b0}}, pend};
    assign pw_idx   = reg_off[OFF_W-1:3];

    // Select the addressed 64-bit pending word.
    always_comb begin
        pba_word = '0;
        for (int w = 0; w < PBA_WORDS; w++)
            if (int'(pw_idx) == w) pba_word = pba_flat[w*64 +: 64];
    end

    // Narrow the pending word to the access size.
    always_comb begin
        case ({reg_size8, reg_off[2:0]})
            4'b1_000: pba_rdata = pba_word;
            4'b0_000: pba_rdata = {32'd0, pba_word[31:0]};
            4'b0_100: pba_rdata = {32'd0, pba_word[63:32]};
            default:  pba_rdata = '0;
        endcase
    end

    // Register read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_valid & ~reg_write;
            if (reg_valid && !reg_write)
                reg_rdata <= reg_space ? pba_rdata : tbl_rdata;
        end
    end

endmodule

// File: rtl/msix_vec_ctrl_chk.sv
// Checker for the MSI-X vector controller ports; bound to every instance.
module msix_vec_ctrl_chk #(
    parameter int VEC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             reg_write,
    input logic             reg_rvalid,
    input logic [15:0]      msg_ctl,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [63:0]      msg_addr,
    input logic [31:0]      msg_data,
    input logic [VEC_W-1:0] msg_vec
);

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec));

    a_r7_fnmask_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && msg_ctl[14] |=> !msg_valid);

    a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && !msg_ctl[15] |=> !msg_valid);

    a_r5_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write |=> reg_rvalid);

    a_r5_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write) |=> !reg_rvalid);

endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_rvalid (reg_rvalid),
    .msg_ctl    (msg_ctl),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .msg_vec    (msg_vec)
);

// File: tb/msix_vec_ctrl_tb.sv
`timescale 1ns/1ps
module msix_vec_ctrl_tb;

    localparam int NV = 70;
    localparam int VW = 7;
    localparam int OW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_valid = 1'b0, reg_write = 1'b0, reg_space = 1'b0, reg_size8 = 1'b0;
    logic [OW-1:0] reg_off = '0;
    logic [63:0]   reg_wdata = '0;
    logic          reg_rvalid;
    logic [63:0]   reg_rdata;
    logic [15:0]   msg_ctl = 16'h0;
    logic [10:0]   table_size;
    logic [NV-1:0] irq_req = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic [VW-1:0] msg_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;
    int log_n = 0;
    logic [VW-1:0] log_vec [0:63];
    logic [63:0]   log_addr [0:63];
    logic [31:0]   log_data [0:63];
    int            log_cyc [0:63];

    msix_vec_ctrl #(.NUM_VEC(NV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_space(reg_space), .reg_off(reg_off), .reg_size8(reg_size8),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .msg_ctl(msg_ctl), .table_size(table_size), .irq_req(irq_req),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_vec(msg_vec)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every accepted message.
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (log_n < 64) begin
                log_vec[log_n]  <= msg_vec;
                log_addr[log_n] <= msg_addr;
                log_data[log_n] <= msg_data;
                log_cyc[log_n]  <= cyc;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_valid = 0; irq_req = '0; msg_ctl = 16'h0; msg_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(bit space, int off, bit s8, logic [63:0] d);
        reg_valid = 1; reg_write = 1; reg_space = space; reg_off = OW'(off); reg_size8 = s8; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(bit space, int off, bit s8, output logic [63:0] d);
        reg_valid = 1; reg_write = 0; reg_space = space; reg_off = OW'(off); reg_size8 = s8;
        @(negedge clk);
        reg_valid = 0;
        d = reg_rdata;
        chk("R5 rvalid after read", 64'(reg_rvalid), 64'd1);
    endtask

    task automatic fire(int v);
        irq_req = '0; irq_req[v] = 1'b1;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        do_reset();
        chk("R1 no message", 64'(msg_valid), 64'd0);
        chk("R5 rvalid idle", 64'(reg_rvalid), 64'd0);
        rd(0, 0, 1, d);      chk("R1 entry0 address", d, 64'd0);
        rd(0, 8, 1, d);      chk("R1 entry0 ctl/data", d, {32'd1, 32'd0});
        rd(0, 69*16+12, 0, d); chk("R1 entry69 ctl", d, 64'd1);
        rd(1, 0, 1, d);      chk("R1 pending word0", d, 64'd0);
        rd(1, 8, 1, d);      chk("R1 pending word1", d, 64'd0);
        chk("R11 table size", 64'(table_size), 64'd69);
    endtask

    task automatic t_layout();
        logic [63:0] d;
        do_reset();
        wr(0, 16'h30, 0, 64'hFFFF_FFFF_A000_0010);
        wr(0, 16'h34, 0, 64'h0000_0000_0000_00A4);
        wr(0, 16'h38, 0, 64'h0000_0000_DA7A_0003);
        rd(0, 16'h30, 1, d); chk("R2 addr hi:lo", d, 64'h0000_00A4_A000_0010);
        rd(0, 16'h38, 0, d); chk("R2 data", d, 64'h0000_0000_DA7A_0003);
        rd(0, 16'h3C, 0, d); chk("R2 ctl still masked", d, 64'd1);
        rd(0, 16'h34, 0, d); chk("R2 addr hi alone", d, 64'h0000_0000_0000_00A4);
    endtask

    task automatic t_wide();
        logic [63:0] d;
        do_reset();
        wr(0, 16'h50, 1, 64'h1111_2222_3333_4444);
        wr(0, 16'h58, 1, 64'h0000_0001_5555_6666);
        rd(0, 16'h50, 0, d); chk("R3 low half of 8B", d, 64'h3333_4444);
        rd(0, 16'h54, 0, d); chk("R3 high half of 8B", d, 64'h1111_2222);
        rd(0, 16'h58, 0, d); chk("R3 data from 8B", d, 64'h5555_6666);
        rd(0, 16'h54, 1, d); chk("R3 8B read at 0x4 is zero", d, 64'd0);
        wr(0, 16'h54, 1, 64'hDEAD_BEEF_DEAD_BEEF);
        wr(0, 16'h52, 0, 64'hDEAD_BEEF);
        rd(0, 16'h50, 1, d); chk("R3 bad-offset writes ignored", d, 64'h1111_2222_3333_4444);
        rd(0, 16'h5C, 1, d); chk("R3 8B read at 0xC is zero", d, 64'd0);
    endtask

    task automatic t_immediate();
        int base;
        do_reset();
        msg_ctl = 16'h8000;
        wr(0, 5*16+0, 1, 64'h0000_0001_FEE0_0050);
        wr(0, 5*16+8, 1, 64'h0000_0000_0000_0A05);
        idle(3);
        base = log_n;
        chk("R8 unmask without pending sends nothing", 64'(log_n - base), 64'd0);
        fire(5);
        idle(4);
        chk("R6 one message", 64'(log_n - base), 64'd1);
        chk("R6 vector", 64'(log_vec[base]), 64'd5);
        chk("R6 address", log_addr[base], 64'h0000_0001_FEE0_0050);
        chk("R6 data", 64'(log_data[base]), 64'h0A05);
    endtask

    task automatic t_masked();
        logic [63:0] d;
        int base;
        do_reset();
        base = log_n;
        wr(0, 5*16+12, 0, 64'd0);
        fire(5);
        idle(4);
        chk("R7 disabled: no message", 64'(log_n - base), 64'd0);
        rd(1, 0, 0, d); chk("R7 disabled: pending set", d, 64'h20);
        msg_ctl = 16'h8000;
        idle(4);
        chk("R7 enable alone delivers nothing", 64'(log_n - base), 64'd0);
        fire(2);
        idle(4);
        chk("R7 masked vector: no message", 64'(log_n - base), 64'd0);
        rd(1, 0, 0, d); chk("R7 pending bits 2 and 5", d, 64'h24);
    endtask

    task automatic t_vec_unmask();
        logic [63:0] d;
        int base;
        do_reset();
        msg_ctl = 16'h8000;
        wr(0, 4*16+0, 0, 64'hFEE0_0040);
        wr(0, 4*16+8, 0, 64'h44);
        base = log_n;
        fire(4);
        idle(3);
        rd(1, 0, 0, d); chk("R8 pending while masked", d, 64'h10);
        wr(0, 4*16+12, 0, 64'd1);
        wr(0, 4*16+0, 0, 64'hFEE0_0044);
        idle(4);
        chk("R8 no message from unchanged or masked write", 64'(log_n - base), 64'd0);
        wr(0, 4*16+12, 0, 64'd0);
        idle(4);
        chk("R8 unmask delivers", 64'(log_n - base), 64'd1);
        chk("R8 vector", 64'(log_vec[base]), 64'd4);
        chk("R8 new address used", log_addr[base], 64'hFEE0_0044);
        rd(1, 0, 0, d); chk("R8 pending cleared", d, 64'd0);
        wr(0, 4*16+12, 0, 64'd0);
        idle(4);
        chk("R8 repeated unmask sends nothing", 64'(log_n - base), 64'd1);
    endtask

    task automatic t_fn_scan();
        logic [63:0] d;
        int base;
        do_reset();
        msg_ctl = 16'hC000;
        wr(0, 2*16+8, 0, 64'd2);  wr(0, 2*16+12, 0, 64'd0);
        wr(0, 5*16+8, 0, 64'd5);  wr(0, 5*16+12, 0, 64'd0);
        wr(0, 65*16+8, 0, 64'd65); wr(0, 65*16+12, 0, 64'd0);
        base = log_n;
        fire(65); fire(5); fire(2); fire(7);
        idle(3);
        chk("R9 nothing while function masked", 64'(log_n - base), 64'd0);
        rd(1, 0, 1, d); chk("R4 word0 pending", d, 64'hA4);
        rd(1, 8, 1, d); chk("R4 word1 pending", d, 64'h2);
        msg_ctl = 16'h8000;
        idle(8);
        chk("R9 three deliveries", 64'(log_n - base), 64'd3);
        chk("R9 first is 2", 64'(log_vec[base]), 64'd2);
        chk("R9 second is 5", 64'(log_vec[base+1]), 64'd5);
        chk("R9 third is 65", 64'(log_vec[base+2]), 64'd65);
        chk("R9 back-to-back", 64'(log_cyc[base+2] - log_cyc[base]), 64'd2);
        chk("R9 data of 65", 64'(log_data[base+2]), 64'd65);
        rd(1, 0, 1, d); chk("R9 masked 7 stays pending", d, 64'h80);
        rd(1, 8, 1, d); chk("R9 word1 cleared", d, 64'd0);
    endtask

    task automatic t_stall();
        int base;
        logic [63:0] a0;
        do_reset();
        msg_ctl = 16'h8000;
        wr(0, 1*16+0, 1, 64'h0000_0002_FEE0_0011);
        wr(0, 1*16+12, 0, 64'd0);
        msg_ready = 1'b0;
        base = log_n;
        fire(1);
        idle(3);
        chk("R10 offered under stall", 64'(msg_valid), 64'd1);
        chk("R10 vector under stall", 64'(msg_vec), 64'd1);
        a0 = msg_addr;
        wr(0, 1*16+0, 1, 64'h0000_0003_0000_0000);
        idle(3);
        chk("R10 still offered", 64'(msg_valid), 64'd1);
        chk("R10 address held", msg_addr, a0);
        chk("R10 no accept while not ready", 64'(log_n - base), 64'd0);
        msg_ready = 1'b1;
        idle(2);
        chk("R10 accepted once ready", 64'(log_n - base), 64'd1);
        chk("R10 valid drops", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_fnmask_hold();
        logic [63:0] d;
        int base;
        do_reset();
        msg_ctl = 16'hC000;
        base = log_n;
        fire(3);
        idle(2);
        wr(0, 3*16+12, 0, 64'd0);
        idle(4);
        chk("R12 no message while function masked", 64'(log_n - base), 64'd0);
        rd(1, 0, 0, d); chk("R12 pending kept", d, 64'h8);
        msg_ctl = 16'h8000;
        idle(5);
        chk("R12 function unmask delivers", 64'(log_n - base), 64'd1);
        chk("R12 vector 3", 64'(log_vec[base]), 64'd3);
    endtask

    task automatic t_pba();
        logic [63:0] d;
        do_reset();
        fire(65); fire(1); fire(63);
        idle(2);
        rd(1, 0, 1, d);  chk("R4 8B word0", d, 64'h8000_0000_0000_0002);
        rd(1, 0, 0, d);  chk("R4 word0 low half", d, 64'h2);
        rd(1, 4, 0, d);  chk("R4 word0 high half", d, 64'h8000_0000);
        rd(1, 8, 0, d);  chk("R4 word1 low half", d, 64'h2);
        rd(1, 12, 0, d); chk("R4 word1 high half", d, 64'h0);
        rd(1, 4, 1, d);  chk("R4 8B at 0x4 zero", d, 64'h0);
        wr(1, 0, 1, 64'd0);
        wr(1, 8, 0, 64'hFFFF_FFFF);
        rd(1, 0, 1, d);  chk("R4 write ignored word0", d, 64'h8000_0000_0000_0002);
        rd(1, 8, 1, d);  chk("R4 write ignored word1", d, 64'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_layout();
        t_wide();
        t_immediate();
        t_masked();
        t_vec_unmask();
        t_fn_scan();
        t_stall();
        t_fnmask_hold();
        t_pba();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule